// File: doc/BRIEF.md
# Instruction-Removal Predictor Table

This block is a prediction table for the leading thread of a redundant pair of threads. It works like a tagged branch-direction predictor, with extra per-instruction state. Each entry describes one dynamic basic block. The entry is found by combining the block's fetch PC with a global branch history register. On every fetch the table returns two things for the block: a taken or not-taken guess for the conditional branch that closes it, and a bit vector naming which of its instruction slots may be dropped from the leading thread.

Training comes from the trailing thread, which sees the real outcomes. An update carries the block's PC, the history value that was in effect when the block was fetched, the real branch direction, and one removable or not-removable flag for each slot. A slot's confidence counter climbs by one for each consecutive removable result and falls back to zero on any other result. The slot is offered for removal only once its counter has reached the threshold.

The table also keeps the global history register. Each prediction is shifted into it. A restore input reloads it when the surrounding pipeline recovers from a misprediction.

Top module: `irp_table`

## Requirements
- R1: After reset, all prediction outputs are zero, `hist_out` is zero, and every entry is empty, so any first lookup misses.
- R2: The entry index is `pc[PC_LSB +: IDX_W]` XOR a fold of the whole history. The fold splits the history into IDX_W-bit chunks, with bit k landing on index bit k mod IDX_W. An entry hits only if it is valid and its stored tag equals the full fetch PC.
- R3: The outputs are registered. In the cycle after a fetch request, `pred_valid` is 1 and the lookup result is shown. In a cycle after no request, `pred_valid`, `pred_hit`, `pred_taken` and `pred_remove` are all zero.
- R4: On a miss, `pred_hit`, `pred_taken` and `pred_remove` are zero.
- R5: The direction is a 2-bit saturating counter with values 0 to 3, where 2 and 3 predict taken. A taken update adds one and saturates at 3. A not-taken update subtracts one and saturates at 0.
- R6: On a hitting update, a slot's confidence counter increments on a removable flag and saturates at 32. It clears to 0 on a not-removable flag.
- R7: Bit i of `pred_remove` covers slot i, with slot 0 at the LSB. The bit is 1 only on a hit whose slot-i counter is at least 32.
- R8: An update that misses reallocates the entry. The tag is set to the update PC, all confidence counters go to 0, and the direction counter goes to 2 if the update was taken or to 1 if it was not.
- R9: A fetch without a restore makes the next history equal to `{hist[HIST_W-2:0], predicted taken}`. The history holds when there is neither a fetch nor a restore.
- R10: A restore loads `restore_hist` into the history on the next cycle and takes priority over the fetch shift.
- R11: When a fetch and an update hit the same entry in one cycle, the fetch sees the contents from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_valid | input | 1 | Lookup request for a block |
| fetch_pc | input | PC_W | Start PC of the fetched block |
| train_valid | input | 1 | Training update present |
| train_pc | input | PC_W | Start PC of the trained block |
| train_hist | input | HIST_W | History in effect when the trained block was fetched |
| train_taken | input | 1 | Resolved branch direction |
| train_removable | input | SLOTS | Per-slot removable flag |
| restore_valid | input | 1 | Reload the history register |
| restore_hist | input | HIST_W | History value to reload |
| hist_out | output | HIST_W | Current global history |
| pred_valid | output | 1 | A prediction is presented this cycle |
| pred_hit | output | 1 | The lookup matched a tag |
| pred_taken | output | 1 | Predicted branch direction |
| pred_remove | output | SLOTS | Per-slot removal vector |

## Verification
The bound checker watches the history on every cycle. It checks that the history shifts in the presented direction after a fetch, that a restore takes priority and loads its value, and that the history stays put when idle. It also checks that a removal vector or a taken guess never appears without a hit, and that nothing is presented without a request. The scenarios cover what needs stored state to show: the removal bit appearing on the 32nd removable update and not the 31st, a single not-removable result clearing a slot, direction saturation, reallocation on aliasing PCs, history-dependent indexing, and a fetch racing an update to the same entry. The reference model is compared with the outputs on every cycle.

// File: rtl/irp_pkg.sv
package irp_pkg;

    typedef logic [1:0] dir_t;

    localparam dir_t DIR_SNT = 2'd0;
    localparam dir_t DIR_WNT = 2'd1;
    localparam dir_t DIR_WT  = 2'd2;
    localparam dir_t DIR_ST  = 2'd3;

    function automatic dir_t dir_step(input dir_t cur, input logic taken);
        dir_t nxt;
        if (taken) nxt = (cur == DIR_ST) ? DIR_ST : cur + 2'd1;
        else       nxt = (cur == DIR_SNT) ? DIR_SNT : cur - 2'd1;
        return nxt;
    endfunction

    function automatic logic dir_is_taken(input dir_t cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/irp_hash.sv
module irp_hash #(
    parameter int HIST_W = 16,
    parameter int IDX_W  = 6
) (
    input  logic [IDX_W-1:0]  pc_bits,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx
);
    localparam int NCHUNK = (HIST_W + IDX_W - 1) / IDX_W;
    localparam int PAD_W  = NCHUNK * IDX_W;

    logic [PAD_W-1:0] padded;

    always_comb begin
        padded = '0;
        padded[HIST_W-1:0] = hist;
        idx = pc_bits;
        for (int c = 0; c < NCHUNK; c++) begin
            idx = idx ^ padded[c*IDX_W +: IDX_W];
        end
    end
endmodule

// File: rtl/irp_conf_slot.sv
module irp_conf_slot #(
    parameter int CONF_W = 6,
    parameter int THRESH = 32
) (
    input  logic [CONF_W-1:0] conf_q,
    input  logic              removable,
    input  logic              realloc,
    output logic [CONF_W-1:0] conf_d
);
    localparam logic [CONF_W-1:0] SAT = CONF_W'(THRESH);

    always_comb begin
        if (realloc || !removable) conf_d = '0;
        else if (conf_q >= SAT)    conf_d = SAT;
        else                       conf_d = conf_q + 1'b1;
    end
endmodule

// File: rtl/irp_lookup.sv
module irp_lookup #(
    parameter int PC_W   = 32,
    parameter int SLOTS  = 16,
    parameter int CONF_W = 6,
    parameter int THRESH = 32
) (
    input  logic                    ent_valid,
    input  logic [PC_W-1:0]         ent_tag,
    input  irp_pkg::dir_t           ent_dir,
    input  logic [SLOTS*CONF_W-1:0] ent_conf,
    input  logic [PC_W-1:0]         pc,
    output logic                    hit,
    output logic                    taken,
    output logic [SLOTS-1:0]        remove
);
    localparam logic [CONF_W-1:0] SAT = CONF_W'(THRESH);

    assign hit   = ent_valid && (ent_tag == pc);
    assign taken = hit && irp_pkg::dir_is_taken(ent_dir);

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign remove[s] = hit && (ent_conf[s*CONF_W +: CONF_W] >= SAT);
    end
endmodule

// File: rtl/irp_train_calc.sv
module irp_train_calc #(
    parameter int PC_W   = 32,
    parameter int SLOTS  = 16,
    parameter int CONF_W = 6,
    parameter int THRESH = 32
) (
    input  logic                    old_valid,
    input  logic [PC_W-1:0]         old_tag,
    input  irp_pkg::dir_t           old_dir,
    input  logic [SLOTS*CONF_W-1:0] old_conf,
    input  logic [PC_W-1:0]         pc,
    input  logic                    taken,
    input  logic [SLOTS-1:0]        removable,
    output logic [PC_W-1:0]         new_tag,
    output irp_pkg::dir_t           new_dir,
    output logic [SLOTS*CONF_W-1:0] new_conf
);
    import irp_pkg::*;

    logic realloc;
    assign realloc = !(old_valid && (old_tag == pc));

    always_comb begin
        new_tag = pc;
        if (realloc) new_dir = taken ? DIR_WT : DIR_WNT;
        else         new_dir = dir_step(old_dir, taken);
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_conf
        irp_conf_slot #(.CONF_W(CONF_W), .THRESH(THRESH)) u_slot (
            .conf_q    (old_conf[s*CONF_W +: CONF_W]),
            .removable (removable[s]),
            .realloc   (realloc),
            .conf_d    (new_conf[s*CONF_W +: CONF_W])
        );
    end
endmodule

// File: rtl/irp_table.sv
module irp_table #(
    parameter int PC_W   = 32,
    parameter int HIST_W = 16,
    parameter int IDX_W  = 6,
    parameter int PC_LSB = 2,
    parameter int SLOTS  = 16,
    parameter int THRESH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [PC_W-1:0]   fetch_pc,
    input  logic              train_valid,
    input  logic [PC_W-1:0]   train_pc,
    input  logic [HIST_W-1:0] train_hist,
    input  logic              train_taken,
    input  logic [SLOTS-1:0]  train_removable,
    input  logic              restore_valid,
    input  logic [HIST_W-1:0] restore_hist,
    output logic [HIST_W-1:0] hist_out,
    output logic              pred_valid,
    output logic              pred_hit,
    output logic              pred_taken,
    output logic [SLOTS-1:0]  pred_remove
);
    import irp_pkg::*;

    localparam int ENTRIES = 1 << IDX_W;
    localparam int CONF_W  = $clog2(THRESH + 1);

    typedef struct packed {
        logic                    valid;
        logic [PC_W-1:0]         tag;
        dir_t                    dir;
        logic [SLOTS*CONF_W-1:0] conf;
    } entry_t;

    typedef struct packed {
        entry_t [ENTRIES-1:0] tbl;
        logic [HIST_W-1:0]    hist;
        logic                 pv;
        logic                 ph;
        logic                 pt;
        logic [SLOTS-1:0]     prm;
    } state_t;

    state_t state_d, state_q;

    logic [IDX_W-1:0] f_idx, t_idx;
    entry_t           f_ent, t_ent;
    logic             f_hit, f_taken;
    logic [SLOTS-1:0] f_remove;
    logic [PC_W-1:0]  t_tag;
    dir_t             t_dir;
    logic [SLOTS*CONF_W-1:0] t_conf;

    irp_hash #(.HIST_W(HIST_W), .IDX_W(IDX_W)) u_fetch_hash (
        .pc_bits (fetch_pc[PC_LSB +: IDX_W]),
        .hist    (state_q.hist),
        .idx     (f_idx)
    );

    irp_hash #(.HIST_W(HIST_W), .IDX_W(IDX_W)) u_train_hash (
        .pc_bits (train_pc[PC_LSB +: IDX_W]),
        .hist    (train_hist),
        .idx     (t_idx)
    );

    assign f_ent = state_q.tbl[f_idx];
    assign t_ent = state_q.tbl[t_idx];

    irp_lookup #(.PC_W(PC_W), .SLOTS(SLOTS), .CONF_W(CONF_W), .THRESH(THRESH)) u_lookup (
        .ent_valid (f_ent.valid),
        .ent_tag   (f_ent.tag),
        .ent_dir   (f_ent.dir),
        .ent_conf  (f_ent.conf),
        .pc        (fetch_pc),
        .hit       (f_hit),
        .taken     (f_taken),
        .remove    (f_remove)
    );

    irp_train_calc #(.PC_W(PC_W), .SLOTS(SLOTS), .CONF_W(CONF_W), .THRESH(THRESH)) u_train (
        .old_valid (t_ent.valid),
        .old_tag   (t_ent.tag),
        .old_dir   (t_ent.dir),
        .old_conf  (t_ent.conf),
        .pc        (train_pc),
        .taken     (train_taken),
        .removable (train_removable),
        .new_tag   (t_tag),
        .new_dir   (t_dir),
        .new_conf  (t_conf)
    );

    always_comb begin
        state_d = state_q;

        state_d.pv  = fetch_valid;
        state_d.ph  = fetch_valid && f_hit;
        state_d.pt  = fetch_valid && f_taken;
        state_d.prm = fetch_valid ? f_remove : '0;

        if (restore_valid)    state_d.hist = restore_hist;
        else if (fetch_valid) state_d.hist = {state_q.hist[HIST_W-2:0], f_taken};

        if (train_valid) begin
            state_d.tbl[t_idx].valid = 1'b1;
            state_d.tbl[t_idx].tag   = t_tag;
            state_d.tbl[t_idx].dir   = t_dir;
            state_d.tbl[t_idx].conf  = t_conf;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign hist_out    = state_q.hist;
    assign pred_valid  = state_q.pv;
    assign pred_hit    = state_q.ph;
    assign pred_taken  = state_q.pt;
    assign pred_remove = state_q.prm;

endmodule

// File: rtl/irp_table_chk.sv
module irp_table_chk #(
    parameter int HIST_W = 16,
    parameter int SLOTS  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_valid,
    input logic              restore_valid,
    input logic [HIST_W-1:0] restore_hist,
    input logic [HIST_W-1:0] hist_out,
    input logic              pred_valid,
    input logic              pred_hit,
    input logic              pred_taken,
    input logic [SLOTS-1:0]  pred_remove
);
    // R10
    restore_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore_valid |=> hist_out == $past(restore_hist));

    // R9
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !restore_valid) |=>
            hist_out == {$past(hist_out[HIST_W-2:0]), pred_taken});

    // R9
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_valid && !restore_valid) |=> $stable(hist_out));

    // R3
    pred_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |=> pred_valid);

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> (!pred_valid && !pred_hit && !pred_taken && pred_remove == '0));

    // R7
    remove_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_remove != '0) |-> pred_hit);

    // R4
    taken_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken |-> pred_hit);
endmodule

bind irp_table irp_table_chk #(.HIST_W(HIST_W), .SLOTS(SLOTS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_valid   (fetch_valid),
    .restore_valid (restore_valid),
    .restore_hist  (restore_hist),
    .hist_out      (hist_out),
    .pred_valid    (pred_valid),
    .pred_hit      (pred_hit),
    .pred_taken    (pred_taken),
    .pred_remove   (pred_remove)
);

// File: tb/irp_table_bench.sv
module irp_table_bench;
    localparam int NE = 64;
    localparam int NS = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        train_valid = 1'b0;
    logic [31:0] train_pc = '0;
    logic [15:0] train_hist = '0;
    logic        train_taken = 1'b0;
    logic [15:0] train_removable = '0;
    logic        restore_valid = 1'b0;
    logic [15:0] restore_hist = '0;
    logic [15:0] hist_out;
    logic        pred_valid, pred_hit, pred_taken;
    logic [15:0] pred_remove;

    always #4 clk = ~clk;

    irp_table u_irp_table (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .train_valid(train_valid), .train_pc(train_pc), .train_hist(train_hist),
        .train_taken(train_taken), .train_removable(train_removable),
        .restore_valid(restore_valid), .restore_hist(restore_hist),
        .hist_out(hist_out), .pred_valid(pred_valid), .pred_hit(pred_hit),
        .pred_taken(pred_taken), .pred_remove(pred_remove)
    );

    int vectors = 0;
    int miscompares = 0;

    bit          m_valid [NE];
    logic [31:0] m_tag   [NE];
    int          m_dir   [NE];
    int          m_conf  [NE][NS];
    logic [15:0] m_hist;
    logic        e_pv, e_ph, e_pt;
    logic [15:0] e_rm;

    function automatic int mhash(logic [31:0] pc, logic [15:0] h);
        int r = int'(pc[7:2]);
        for (int k = 0; k < 16; k++) if (h[k]) r = r ^ (1 << (k % 6));
        return r;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NE; i++) begin
            m_valid[i] = 0; m_tag[i] = '0; m_dir[i] = 0;
            for (int s = 0; s < NS; s++) m_conf[i][s] = 0;
        end
        m_hist = '0; e_pv = 0; e_ph = 0; e_pt = 0; e_rm = '0;
    endtask

    task automatic model_update();
        int fi, ti;
        e_pv = 0; e_ph = 0; e_pt = 0; e_rm = '0;
        if (fetch_valid) begin
            fi = mhash(fetch_pc, m_hist);
            e_pv = 1;
            e_ph = m_valid[fi] && (m_tag[fi] == fetch_pc);
            e_pt = e_ph && (m_dir[fi] >= 2);
            for (int s = 0; s < NS; s++) e_rm[s] = e_ph && (m_conf[fi][s] >= 32);
        end
        if (train_valid) begin
            ti = mhash(train_pc, train_hist);
            if (m_valid[ti] && m_tag[ti] == train_pc) begin
                if (train_taken) m_dir[ti] = (m_dir[ti] == 3) ? 3 : m_dir[ti] + 1;
                else             m_dir[ti] = (m_dir[ti] == 0) ? 0 : m_dir[ti] - 1;
                for (int s = 0; s < NS; s++)
                    m_conf[ti][s] = train_removable[s] ?
                        ((m_conf[ti][s] >= 32) ? 32 : m_conf[ti][s] + 1) : 0;
            end else begin
                m_valid[ti] = 1; m_tag[ti] = train_pc;
                m_dir[ti] = train_taken ? 2 : 1;
                for (int s = 0; s < NS; s++) m_conf[ti][s] = 0;
            end
        end
        if (restore_valid)    m_hist = restore_hist;
        else if (fetch_valid) m_hist = {m_hist[14:0], e_pt};
    endtask

    task automatic compare(string tag);
        vectors++;
        if (pred_valid !== e_pv || pred_hit !== e_ph || pred_taken !== e_pt ||
            pred_remove !== e_rm || hist_out !== m_hist) begin
            miscompares++;
            $display("FAIL %s: actual v=%0b h=%0b t=%0b rm=%h hist=%h expected v=%0b h=%0b t=%0b rm=%h hist=%h",
                     tag, pred_valid, pred_hit, pred_taken, pred_remove, hist_out,
                     e_pv, e_ph, e_pt, e_rm, m_hist);
        end
    endtask

    task automatic cycle(string tag);
        @(posedge clk);
        model_update();
        #2;
        compare(tag);
        fetch_valid = 0; train_valid = 0; restore_valid = 0;
    endtask

    task automatic do_train(logic [31:0] pc, logic [15:0] h, logic tk, logic [15:0] rem, string tag);
        train_valid = 1; train_pc = pc; train_hist = h; train_taken = tk; train_removable = rem;
        cycle(tag);
    endtask

    task automatic set_hist(logic [15:0] h, string tag);
        restore_valid = 1; restore_hist = h;
        cycle(tag);
    endtask

    task automatic fetch_at(logic [31:0] pc, logic [15:0] h, string tag);
        set_hist(h, tag);
        fetch_valid = 1; fetch_pc = pc;
        cycle(tag);
    endtask

    localparam logic [31:0] PA = 32'h0000_1040;
    localparam logic [31:0] PB = 32'h0000_2040;
    localparam logic [31:0] PC3 = 32'h0000_3a7c;

    initial begin
        #(8 * 200000);
        $display("FAIL watchdog: actual running expected finished");
        miscompares++;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        cycle("R1 reset state");
        fetch_valid = 1; fetch_pc = PA;
        cycle("R1 first lookup misses");

        fetch_at(PA, 16'h0000, "R4 miss output");
        do_train(PA, 16'h0000, 1'b1, 16'h0005, "R8 allocate");
        fetch_at(PA, 16'h0000, "R8 allocated weakly taken, no removal");

        for (int i = 0; i < 31; i++) do_train(PA, 16'h0000, 1'b1, 16'h0005, "R6 climb");
        fetch_at(PA, 16'h0000, "R7 count 31 not yet removable");
        do_train(PA, 16'h0000, 1'b1, 16'h0005, "R6 reach 32");
        fetch_at(PA, 16'h0000, "R7 count 32 removable");
        for (int i = 0; i < 5; i++) do_train(PA, 16'h0000, 1'b1, 16'h0005, "R6 saturate");
        fetch_at(PA, 16'h0000, "R6 saturated stays removable");
        do_train(PA, 16'h0000, 1'b1, 16'h0004, "R6 slot0 not removable");
        fetch_at(PA, 16'h0000, "R6 slot0 cleared");

        for (int i = 0; i < 4; i++) do_train(PA, 16'h0000, 1'b0, 16'h0004, "R5 down");
        fetch_at(PA, 16'h0000, "R5 saturated not-taken");
        do_train(PA, 16'h0000, 1'b1, 16'h0004, "R5 up1");
        fetch_at(PA, 16'h0000, "R5 one step still not taken");
        do_train(PA, 16'h0000, 1'b1, 16'h0004, "R5 up2");
        fetch_at(PA, 16'h0000, "R5 two steps taken");

        fetch_at(PB, 16'h0000, "R2 alias pc misses on tag");
        do_train(PB, 16'h0000, 1'b0, 16'hffff, "R8 realloc by alias");
        fetch_at(PA, 16'h0000, "R8 old block evicted");
        fetch_at(PB, 16'h0000, "R8 new block hits");

        do_train(PC3, 16'hbeef, 1'b1, 16'h8001, "R2 train under history");
        fetch_at(PC3, 16'hbeef, "R2 hit under same history");
        fetch_at(PC3, 16'h0000, "R2 other history indexes elsewhere");

        set_hist(16'h1234, "R10 restore");
        fetch_valid = 1; fetch_pc = PC3; restore_valid = 1; restore_hist = 16'h0f0f;
        cycle("R10 restore beats fetch shift");
        fetch_valid = 1; fetch_pc = PC3;
        cycle("R9 shift");
        fetch_at(PC3, 16'hbeef, "R9 shift in taken");
        fetch_valid = 1; fetch_pc = PB;
        cycle("R9 shift again");
        cycle("R3 idle quiet");

        set_hist(16'h0000, "R11 setup");
        fetch_valid = 1; fetch_pc = PB;
        train_valid = 1; train_pc = PB; train_hist = 16'h0000; train_taken = 1; train_removable = 16'h0;
        cycle("R11 fetch sees pre-update");
        fetch_at(PB, 16'h0000, "R11 update visible later");

        for (int i = 0; i < 600; i++) begin
            logic [31:0] pcs [4];
            pcs[0] = PA; pcs[1] = PB; pcs[2] = PC3; pcs[3] = 32'h0000_0104;
            fetch_valid = ($urandom % 3) != 0;
            fetch_pc = pcs[$urandom % 4];
            train_valid = ($urandom % 2) != 0;
            train_pc = pcs[$urandom % 4];
            train_hist = ($urandom % 2) ? 16'h0000 : 16'hbeef;
            train_taken = $urandom % 2;
            train_removable = ($urandom % 8 != 0) ? 16'h00ff : 16'(($urandom));
            restore_valid = ($urandom % 4) == 0;
            restore_hist = ($urandom % 2) ? 16'h0000 : 16'hbeef;
            cycle("R2 random mix");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule